// File: doc/BRIEF.md
# Start/Stop Down-Counter Timer

This block is a 16-bit down-counter that hangs off a peripheral's byte-wide register bus. Software sets the reload value one byte at a time and picks the operating mode with one bit of a control register. Reads of two command addresses start and stop the count, so a read has a side effect. The count advances only on cycles where the `tick` enable is high.

When the count steps down to zero, a terminal event flag is raised. This flag is meant to feed an interrupt status bit, and an external clear input drops it. In one-shot counter mode the count stops at zero. In timer mode it reloads and keeps running, which gives a periodic event. The stop command behaves differently in each mode.

Top module: `cmd_ctr_timer`

## Requirements
- R1: After reset the count is 0, the counter is running, the event flag is low, the control byte is 0 (counter mode) and both preload bytes are 0.
- R2: A write to address 0 replaces only the upper preload byte. A write to address 1 replaces only the lower preload byte. The preload is {upper, lower}.
- R3: A read of address 3 (start) copies the preload into the count and sets running. A tick in the same cycle is ignored.
- R4: While running, each cycle with `tick` high lowers the count by one, modulo 2^16 (0 steps to 0xFFFF). Cycles without a tick, and ticks while halted, leave the count unchanged.
- R5: A tick that brings the count from 1 to 0 sets the event flag. The flag then stays high until it is cleared.
- R6: In counter mode (bit 6 of the control byte written at address 2 is 0), reaching zero halts counting and leaves the count at 0.
- R7: In timer mode (that bit is 1), reaching zero reloads the count from the preload and counting continues.
- R8: A read of address 4 (stop) clears the event flag in either mode.
- R9: In counter mode, the stop read also halts counting and reloads the count from the preload. A tick in the same cycle is ignored.
- R10: In timer mode, the stop read leaves the count and the running state untouched.
- R11: `flag_clr` clears the event flag. If a tick reaches zero in the same cycle as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (start/stop commands) |
| bus_wdata | input | 8 | Write data byte |
| tick | input | 1 | Count enable |
| flag_clr | input | 1 | Clear for the event flag |
| count_o | output | 16 | Current count |
| running_o | output | 1 | Counting is active |
| event_o | output | 1 | Terminal-count event flag |

## Verification
The count, running and event registers all appear at the ports. A wrong next-state choice (a missed reload, a halt in the wrong mode, a lost wrap) therefore shows on `count_o` or `running_o` in the cycle right after the offending edge. The reload value sits in hidden preload bytes. A corrupted byte stays invisible until the next start, counter-mode stop or timer-mode reload, and then shows as a wrong count one cycle later. For every preload from 1 to 12 and in both modes, the bench compares the count against its arithmetic value after every tick and every idle cycle.

// File: rtl/cmd_ctr_timer.sv
module cmd_ctr_timer #(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int MODE_BIT = 6,
  parameter logic [ADDR_W-1:0] A_PRE_HI = 3'd0,
  parameter logic [ADDR_W-1:0] A_PRE_LO = 3'd1,
  parameter logic [ADDR_W-1:0] A_CTRL   = 3'd2,
  parameter logic [ADDR_W-1:0] A_START  = 3'd3,
  parameter logic [ADDR_W-1:0] A_STOP   = 3'd4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  logic                tick,
  input  logic                flag_clr,
  output logic [2*BYTE_W-1:0] count_o,
  output logic                running_o,
  output logic                event_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] pre_hi, pre_lo;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, evt_q, mode_q;

  wire [CNT_W-1:0] preload   = {pre_hi, pre_lo};
  wire             do_start  = bus_rd && (bus_addr == A_START);
  wire             do_stop   = bus_rd && (bus_addr == A_STOP);
  wire             stop_halt = do_stop && !mode_q;
  wire             adv       = run_q && tick && !do_start && !stop_halt;
  wire [CNT_W-1:0] cnt_dec   = cnt_q - CNT_W'(1);
  wire             hit       = adv && (cnt_dec == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_hi <= '0;
      pre_lo <= '0;
      mode_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_PRE_HI) pre_hi <= bus_wdata;
      if (bus_addr == A_PRE_LO) pre_lo <= bus_wdata;
      if (bus_addr == A_CTRL)   mode_q <= bus_wdata[MODE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (do_start) begin
      cnt_q <= preload;
      run_q <= 1'b1;
    end else if (stop_halt) begin
      cnt_q <= preload;
      run_q <= 1'b0;
    end else if (adv) begin
      if (hit && mode_q) begin
        cnt_q <= preload;
      end else begin
        cnt_q <= cnt_dec;
        if (hit) run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    evt_q <= 1'b0;
    else if (hit)                  evt_q <= 1'b1;
    else if (do_stop || flag_clr)  evt_q <= 1'b0;
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;
  assign event_o   = evt_q;

  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> (count_o == $past(preload)) && running_o);
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tick && !bus_rd && count_o == '0) |=> count_o == '1);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !bus_rd) |=> $stable(count_o));
  a_r5_event_set: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tick && !bus_rd && count_o == CNT_W'(1)) |=> event_o);
  a_r6_halt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tick && !bus_rd && !mode_q && count_o == CNT_W'(1)) |=> !running_o && count_o == '0);
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stop && !(tick && running_o && mode_q && count_o == CNT_W'(1))) |=> !event_o);
  a_r10_timer_stop_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (do_stop && mode_q && running_o) |=> running_o);
endmodule

// File: tb/cmd_ctr_timer_bench.sv
module cmd_ctr_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tick = 1'b0, flag_clr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] count_o;
  logic        running_o, event_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ctr_timer u_cmd_ctr_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .tick(tick), .flag_clr(flag_clr),
    .count_o(count_o), .running_o(running_o), .event_o(event_o));

  task automatic cyc(input logic rd, input logic wr, input logic [2:0] a,
                     input logic [7:0] d, input logic tk, input logic clr);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk; flag_clr = clr;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; tick = 0; flag_clr = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [15:0] c, input logic r, input logic e);
    chk({req, " count"}, count_o, c);
    chk({req, " running"}, {15'd0, running_o}, {15'd0, r});
    chk({req, " event"}, {15'd0, event_o}, {15'd0, e});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(0, 1, a, d, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1 reset", 16'h0000, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk_all("R4 wrap from zero", 16'hFFFF, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk_all("R4 decrement", 16'hFFFE, 1, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk_all("R4 no tick holds", 16'hFFFE, 1, 0);
    cyc(1, 0, 3, 0, 0, 0);
    chk_all("R1 preload resets to zero", 16'h0000, 1, 0);

    wr(0, 8'hAB); wr(1, 8'hCD);
    cyc(1, 0, 3, 0, 0, 0);
    chk_all("R2 both bytes", 16'hABCD, 1, 0);
    wr(0, 8'h12);
    cyc(1, 0, 3, 0, 0, 0);
    chk_all("R2 upper only", 16'h12CD, 1, 0);
    wr(1, 8'h34);
    cyc(1, 0, 3, 0, 0, 0);
    chk_all("R2 lower only", 16'h1234, 1, 0);

    wr(0, 8'h00); wr(1, 8'h20);
    cyc(1, 0, 3, 0, 1, 0);
    chk_all("R3 start beats tick", 16'h0020, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 0, 4, 0, 1, 0);
    chk_all("R9 counter stop beats tick", 16'h0020, 0, 0);

    wr(1, 8'h01);
    cyc(1, 0, 3, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1);
    chk_all("R11 set wins over clear", 16'h0000, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    chk_all("R11 clear input", 16'h0000, 0, 0);
    cyc(1, 0, 4, 0, 0, 0);

    for (int m = 0; m < 2; m++) begin
      for (int p = 1; p <= 12; p++) begin
        logic [15:0] ec;
        logic er, ee;
        wr(0, 8'h00); wr(1, 8'(p)); wr(2, m ? 8'h40 : 8'h00);
        cyc(1, 0, 3, 0, 0, 0);
        chk_all("R3 start in sweep", 16'(p), 1, 0);
        for (int k = 1; k <= 3 * p; k++) begin
          cyc(0, 0, 0, 0, 1, 0);
          if (m == 1) begin
            ec = 16'(p - (k % p)); er = 1;
          end else begin
            ec = (k >= p) ? 16'd0 : 16'(p - k); er = (k < p);
          end
          ee = (k >= p);
          chk_all(m ? "R7 timer sweep" : "R6 counter sweep", ec, er, ee);
          cyc(0, 0, 0, 0, 0, 0);
          chk_all("R5 R4 idle cycle holds", ec, er, ee);
        end
        cyc(1, 0, 4, 0, 0, 0);
        if (m == 1) chk_all("R10 R8 timer stop", ec, 1, 0);
        else        chk_all("R9 R8 counter stop", 16'(p), 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        if (m == 1) chk_all("R10 timer keeps counting", (ec == 16'd1) ? 16'(p) : ec - 16'd1, 1, (ec == 16'd1));
        else        chk_all("R4 halted ignores tick", 16'(p), 0, 0);
        cyc(1, 0, 4, 0, 0, 0);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule